// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Lock

This block watches over software by counting down from a programmed timeout. Software has to restart the count in time by writing a fixed key to a restart address. If it does not, the block raises a reset request toward the chip's reset logic. The count advances on one of two timebases: an internal tick made by dividing the system clock, or a strobe from an alternate tick source.

Two optional protections sit on top of the basic reload-and-expire counter. The first is window mode, which also punishes a restart that comes too early. The second is a lock bit that can only be set. Once set, it freezes the configuration so that a runaway program cannot stop or slow the watchdog. A sticky cause flag records that the last reset request came from this block. Software writes 1 to the flag to clear it.

Register writes use a small synchronous interface: a write strobe, a 3-bit address and 16 data bits. The current count and the enable state are brought out as plain outputs.

Top module: `wdog_win`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `rst_req` is 0, `wdt_cause` is 0, `count` is 0 and `active` is 0. The lock is clear in this state.
- R2: The control register sits at address 0, with enable in bit 0. Writing it with the enable bit going from 0 to 1 starts the watchdog: `active` goes to 1 and `count` loads the timeout (address 1) on the same edge. After that, `count` drops by one on each edge that sees a tick of the selected timebase.
- R3: With timeout T≥1 and no restart, `rst_req` rises on the edge that consumes the T-th tick. A timeout of 0 expires on the first tick.
- R4: Control bit 1 selects the timebase. A value of 0 selects the internal tick, one every 4 system clocks counted from the start. A value of 1 selects `alt_tick`, with one decrement per clock in which it is high.
- R5: A write of 0xA5C3 to address 3 while `active` is 1 reloads `count` with the timeout. A write of any other value to address 3 leaves `count` unchanged.
- R6: Control bit 2 enables window mode. In this mode a key write is accepted only when `count` ≤ the window threshold (address 2). A key write while `count` is above the threshold raises `rst_req` on that same edge.
- R7: If an accepted restart and the tick that would expire the count fall in the same cycle, the restart wins: `count` reloads and `rst_req` stays 0.
- R8: `rst_req` is high for exactly 4 clocks. On the edge where it rises, `active` drops to 0 and `count` goes to 0. A write that sets enable while `rst_req` is high is ignored. A later enable write starts the watchdog again.
- R9: `wdt_cause` goes to 1 whenever a reset request is raised. It is cleared by writing 1 to bit 0 of address 4. If the set and the clear fall in the same cycle, the set wins.
- R10: Control bit 3 is the lock, and software can only set it. While the lock is set, writes to addresses 1 and 2 and to control bits 1 to 3 have no effect, and enable cannot be cleared but can still be set. Only `rst_n` clears the lock.
- R11: Changing the timeout while the watchdog runs does not change `count`. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| alt_tick | input | 1 | Alternate timebase strobe, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| rst_req | output | 1 | Reset request pulse |
| wdt_cause | output | 1 | Sticky flag: last reset request came from the watchdog |
| count | output | 16 | Current down-counter value |
| active | output | 1 | Watchdog enabled and counting |

## Verification
Two collisions are provoked deliberately. In the first, with the count at 1, the bench raises `alt_tick` in the same cycle as a valid key write. The case passes only if the count reloads to the timeout and no reset request appears. In the second, the final expiring tick arrives in the same cycle as a write-1 clear of the cause flag, and the flag must read 1 afterwards. A window sweep then places the key write at every count level of a small timeout, so that acceptance and violation are judged on both sides of the threshold.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_WIN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FEED = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int B_EN   = 0;
  localparam int B_SEL  = 1;
  localparam int B_WINM = 2;
  localparam int B_LOCK = 3;

  // count is inside the window when at or below the threshold
  function automatic logic fn_win_ok(input logic [15:0] cnt, input logic [15:0] thr);
    return cnt <= thr;
  endfunction

  // the tick that sees this count is the expiring one
  function automatic logic fn_last(input logic [15:0] cnt);
    return cnt <= 16'd1;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] FEED_KEY = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hw_stop,
  input  logic              busy,
  output logic              en_o,
  output logic              sel_o,
  output logic              winm_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] tmo_o,
  output logic [DATA_W-1:0] win_o,
  output logic              cause_o,
  output logic              start_o,
  output logic              feed_hit_o
);
  logic en_q, sel_q, winm_q, lock_q, cause_q;
  logic [DATA_W-1:0] tmo_q, win_q;
  logic ctrl_wr, tmo_wr, win_wr, stat_clr, en_req;

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign tmo_wr   = wr_en && (wr_addr == A_TMO) && !lock_q;
  assign win_wr   = wr_en && (wr_addr == A_WIN) && !lock_q;
  assign stat_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign en_req   = ctrl_wr && wr_data[B_EN];
  assign start_o  = en_req && !en_q && !busy && !hw_stop;
  assign feed_hit_o = wr_en && (wr_addr == A_FEED) && (wr_data == FEED_KEY) && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sel_q <= 1'b0; winm_q <= 1'b0; lock_q <= 1'b0;
      cause_q <= 1'b0; tmo_q <= '0; win_q <= '0;
    end else begin
      if (hw_stop)
        en_q <= 1'b0;
      else if (ctrl_wr) begin
        if (lock_q) en_q <= en_q || (wr_data[B_EN] && !busy);
        else        en_q <= wr_data[B_EN] && (en_q || !busy);
      end
      if (ctrl_wr && !lock_q) begin
        sel_q  <= wr_data[B_SEL];
        winm_q <= wr_data[B_WINM];
        lock_q <= wr_data[B_LOCK];
      end
      if (tmo_wr) tmo_q <= wr_data;
      if (win_wr) win_q <= wr_data;
      if (hw_stop)       cause_q <= 1'b1;
      else if (stat_clr) cause_q <= 1'b0;
    end
  end

  assign en_o = en_q;   assign sel_o = sel_q;  assign winm_o = winm_q;
  assign lock_o = lock_q; assign tmo_o = tmo_q; assign win_o = win_q;
  assign cause_o = cause_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q); // R10
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(tmo_q) && $stable(win_q) && $stable(sel_q) && $stable(winm_q))); // R10
  AST_LOCK_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q && !hw_stop) |=> en_q); // R10
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n) hw_stop |=> cause_q); // R9
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic start_i,
  input  logic sel_i,
  input  logic alt_tick_i,
  output logic tick_o
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (start_i) pre_q <= '0;
    else if (run_i)   pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end

  assign int_tick = run_i && (pre_q == PRE_LAST);
  assign tick_o   = sel_i ? (run_i && alt_tick_i) : int_tick;

  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i); // R2
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             winm_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             feed_hit_i,
  input  logic [CNT_W-1:0] tmo_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             trigger_o,
  output logic             busy_o,
  output logic             rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic in_window, feed_accept, feed_violate, expire;

  assign in_window    = !winm_i || fn_win_ok(16'(cnt_q), 16'(win_i));
  assign feed_accept  = feed_hit_i && in_window;
  assign feed_violate = feed_hit_i && !in_window;
  assign expire       = en_i && tick_i && fn_last(16'(cnt_q)) && !feed_accept;
  assign trigger_o    = feed_violate || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= tmo_i;
    else if (trigger_o)      cnt_q <= '0;
    else if (feed_accept)    cnt_q <= tmo_i;
    else if (en_i && tick_i) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse_q <= '0;
    else if (trigger_o)      pulse_q <= PULSE_INIT;
    else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
  end

  assign busy_o    = (pulse_q != '0);
  assign rst_req_o = busy_o;
  assign cnt_o     = cnt_q;

  AST_REQ_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(trigger_o)); // R3
  AST_STOPPED_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !en_i); // R8
  AST_FEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_accept && !start_i) |=> (cnt_o == $past(tmo_i))); // R5
  AST_NO_EARLY_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_hit_i && winm_i && (cnt_q > win_i)) |=> rst_req_o); // R6
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PRE_DIV   = 4,
  parameter int PULSE_LEN = 4,
  parameter logic [DATA_W-1:0] FEED_KEY = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_req,
  output logic              wdt_cause,
  output logic [DATA_W-1:0] count,
  output logic              active
);
  logic en, sel, winm, lock, start, feed_hit, trigger, busy, tick;
  logic [DATA_W-1:0] tmo, win;

  wdog_regs #(.DATA_W(DATA_W), .FEED_KEY(FEED_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_stop(trigger), .busy(busy), .en_o(en), .sel_o(sel), .winm_o(winm),
    .lock_o(lock), .tmo_o(tmo), .win_o(win), .cause_o(wdt_cause),
    .start_o(start), .feed_hit_o(feed_hit)
  );

  wdog_tick #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(en && !busy), .start_i(start),
    .sel_i(sel), .alt_tick_i(alt_tick), .tick_o(tick)
  );

  wdog_core #(.CNT_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(en), .winm_i(winm), .tick_i(tick),
    .start_i(start), .feed_hit_i(feed_hit), .tmo_i(tmo), .win_i(win),
    .cnt_o(count), .trigger_o(trigger), .busy_o(busy), .rst_req_o(rst_req)
  );

  assign active = en;

  AST_LOCK_NO_CLEAR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && active && !trigger) |=> active); // R10
endmodule

// File: tb/wdog_win_test.sv
module wdog_win_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alt_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic rst_req, wdt_cause, active;
  logic [15:0] count;

  localparam logic [15:0] KEY = 16'hA5C3;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wdog_win uut (.clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req), .wdt_cause(wdt_cause),
    .count(count), .active(active));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write spanning one posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit tk = 0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; alt_tick = tk;
    @(negedge clk);
    wr_en = 1'b0; alt_tick = 1'b0;
  endtask

  task automatic tick1();
    alt_tick = 1'b1;
    @(negedge clk);
    alt_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (bench did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    chk("R1 rst_req in reset", rst_req, 0);
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 cause", wdt_cause, 0);
    chk("R1 count", count, 0);
    chk("R1 active", active, 0);

    // R2 R3 R8 R9 sweep over timeouts with alternate ticks
    for (int t = 0; t <= 6; t++) begin
      wr(3'd1, 16'(t));
      wr(3'd0, 16'h0003);
      chk("R2 load", count, t);
      chk("R2 active", active, 1);
      for (int k = 1; k < ((t == 0) ? 1 : t); k++) begin
        tick1();
        chk("R2 decrement", count, t - k);
        chk("R3 no early req", rst_req, 0);
      end
      tick1();
      chk("R3 expiry", rst_req, 1);
      chk("R8 stopped", active, 0);
      chk("R8 count zero", count, 0);
      chk("R9 cause set", wdt_cause, 1);
      if (t == 2) begin
        wr(3'd0, 16'h0003);
        chk("R8 enable during pulse ignored", active, 0);
        pulse_len(n);
        chk("R8 pulse width", n + 1, 4);
      end else begin
        pulse_len(n);
        chk("R8 pulse width", n, 4);
      end
      wr(3'd4, 16'h0001);
      chk("R9 cause cleared", wdt_cause, 0);
    end

    // R4 internal timebase, 4 clocks per tick
    for (int t = 1; t <= 3; t++) begin
      wr(3'd1, 16'(t));
      wr(3'd0, 16'h0001);
      n = 0;
      while (!rst_req && n < 100) begin @(negedge clk); n++; end
      chk("R4 internal tick period", n, 4 * t);
      idle(5);
    end

    // R5 key handling, R11 timeout change while running
    wr(3'd1, 16'd9);
    wr(3'd0, 16'h0003);
    tick1(); tick1();
    wr(3'd3, 16'hA5C2);
    chk("R5 wrong key ignored", count, 7);
    wr(3'd3, KEY);
    chk("R5 key reloads", count, 9);
    wr(3'd1, 16'd5);
    chk("R11 running count kept", count, 9);
    tick1();
    wr(3'd3, KEY);
    chk("R11 new timeout on reload", count, 5);

    // R7 feed and final tick in the same cycle
    for (int k = 0; k < 4; k++) tick1();
    chk("R7 count at one", count, 1);
    wr(3'd3, KEY, 1);
    chk("R7 feed wins count", count, 5);
    chk("R7 feed wins no req", rst_req, 0);
    wr(3'd0, 16'h0000);
    chk("R2 disable", active, 0);

    // R6 window sweep: timeout 6, threshold 2
    wr(3'd1, 16'd6);
    wr(3'd2, 16'd2);
    for (int k = 0; k <= 5; k++) begin
      wr(3'd0, 16'h0007);
      for (int j = 0; j < k; j++) tick1();
      wr(3'd3, KEY);
      if (6 - k <= 2) begin
        chk("R6 in-window accepted", count, 6);
        chk("R6 in-window no req", rst_req, 0);
        wr(3'd0, 16'h0000);
      end else begin
        chk("R6 early feed req", rst_req, 1);
        idle(5);
      end
    end
    wr(3'd4, 16'h0001);

    // R9 set wins over simultaneous clear
    wr(3'd1, 16'd1);
    wr(3'd0, 16'h0003);
    wr(3'd4, 16'h0001, 1);
    chk("R9 set beats clear", wdt_cause, 1);
    idle(5);

    // R10 lock
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h000B);
    wr(3'd1, 16'd12);
    wr(3'd0, 16'h0000);
    chk("R10 enable not clearable", active, 1);
    wr(3'd3, KEY);
    chk("R10 timeout frozen", count, 4);
    wr(3'd0, 16'h0000);
    for (int k = 0; k < 4; k++) tick1();
    chk("R10 sel frozen expiry", rst_req, 1);
    idle(5);
    wr(3'd0, 16'h0001);
    chk("R10 enable settable when locked", active, 1);
    chk("R10 locked reload value", count, 4);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears state", active, 0);
    wr(3'd1, 16'd7);
    wr(3'd0, 16'h0003);
    chk("R10 lock cleared by reset", count, 7);
    wr(3'd0, 16'h0000);
    chk("R10 unlocked disable", active, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule